// File: doc/BRIEF.md
# Reloadable Down-Counting Timer

The block is a 32-bit timer that counts down and reloads itself. Software reaches it through a small word-addressed register port with four registers: control, current count, reload value and event status. When the count steps past 1 it takes the reload value again and records an event in the status flag. The flag drives an interrupt line when software has enabled it, and it stays set until software writes a 1 to clear it.

An external input can take part in counting in two ways. It can act as a gate, so that counting pauses while the input is low. It can also act as the count clock, so that the counter steps once per rising edge of the input instead of once per system clock. The input passes through a two-flop synchronizer, and its rising edges are found in the system clock domain. The register port has no wait states. Writes take effect at the clock edge where they are presented, and read data is returned in the same cycle.

Top module: `rl_timer`

## Requirements
- R1: After reset, all four registers read zero and `irq_o` is low.
- R2: The registers sit at byte offsets 0x0 (control), 0x4 (count), 0x8 (reload) and 0xC (status). An access whose address has bits [1:0] nonzero, or any bit above bit 3 set, neither writes nor returns data, and its read data is 0. A write to reload also loads the count. A write to count leaves reload unchanged.
- R3: Control bit 0 enables counting. While it is 0 the count holds its value. While it is 1, with no other mode selected, the count steps down once per clock cycle.
- R4: Control bit 1 selects gating. While it is set, no step occurs while the synchronized external input is low. While that input is high, steps occur every cycle. The input reaches the counter two clock cycles after it changes.
- R5: Control bit 2 selects external clocking. While it is set, exactly one step occurs for each rising edge of the synchronized external input, and none occurs while the input is steady.
- R6: A step taken with the count at 1 loads the reload value and sets status bit 0. A step taken with the count at 0 loads the reload value without setting the flag. With a reload value of 0, the count therefore stays at 0 and raises no further events.
- R7: Writing status with bit 0 = 1 clears the flag, and writing bit 0 = 0 leaves it unchanged. If an event and a clearing write fall in the same cycle, the flag ends up set.
- R8: `irq_o` is a registered output equal to status bit 0 AND control bit 3 in every cycle. The flag is recorded whether or not bit 3 is set.
- R9: Control bits 31:4 read as zero, and writing them has no effect on behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to `clk` |
| reg_valid | input | 1 | Register access is presented this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (8) | Byte address of the register |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, valid in the same cycle as a read |
| ext_in | input | 1 | External gate or count clock, asynchronous to `clk` |
| irq_o | output | 1 | Timer interrupt, level, registered |

## Verification
A wrong count or a lost step shows up in the count register at the next read. A stuck or missed status flag shows in the status read and on `irq_o` in the cycle after the edge where the event should have happened. An error in synchronizer or edge-detect state shows up as a wrong number of steps after a known number of external pulses. The bench therefore applies exact pulse and cycle counts and compares the final count. It also lines up a clearing write with an expiry in the same edge, so that a clear-wins bug shows as a zero flag one cycle later.

// File: rtl/rl_timer_pkg.sv
package rl_timer_pkg;

  localparam int unsigned CTRL_W = 4;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_RELOAD = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  // Bit 0 = en, bit 1 = gate, bit 2 = xclk, bit 3 = ie
  typedef struct packed {
    logic ie;
    logic xclk;
    logic gate;
    logic en;
  } ctrl_t;

endpackage

// File: rtl/rl_timer_extin.sv
module rl_timer_extin #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic ext_lvl,
  output logic ext_rise
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], ext_in};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign ext_lvl  = sync_q[SYNC_STAGES-1];
  assign ext_rise = ext_lvl & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise) else $error("rise pulse longer than one cycle"); // R5

endmodule

// File: rtl/rl_timer_regif.sv
module rl_timer_regif
  import rl_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CTRL_W-1:0] wdata_lo,
  input  logic [DATA_W-1:0] count_q,
  input  logic [DATA_W-1:0] reload_q,
  input  logic              status_q,
  output ctrl_t             ctrl_q,
  output ctrl_t             ctrl_nxt,
  output logic              wr_count,
  output logic              wr_reload,
  output logic              wr_status,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam int unsigned SEL_LSB = 2;
  localparam int unsigned SEL_MSB = SEL_LSB + 1;

  logic     addr_ok;
  logic     wr_hit;
  logic     rd_hit;
  logic     wr_ctrl;
  reg_sel_e sel;

  always_comb begin
    addr_ok   = (reg_addr[SEL_LSB-1:0] == '0) && (reg_addr[ADDR_W-1:SEL_MSB+1] == '0);
    sel       = reg_sel_e'(reg_addr[SEL_MSB:SEL_LSB]);
    wr_hit    = reg_valid & reg_write & addr_ok;
    rd_hit    = reg_valid & ~reg_write & addr_ok;
    wr_ctrl   = wr_hit & (sel == SEL_CTRL);
    wr_count  = wr_hit & (sel == SEL_COUNT);
    wr_reload = wr_hit & (sel == SEL_RELOAD);
    wr_status = wr_hit & (sel == SEL_STATUS);
    ctrl_nxt  = wr_ctrl ? ctrl_t'(wdata_lo) : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_nxt;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (rd_hit) begin
      unique case (sel)
        SEL_CTRL:   reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        SEL_COUNT:  reg_rdata = count_q;
        SEL_RELOAD: reg_rdata = reload_q;
        SEL_STATUS: reg_rdata = {{(DATA_W-1){1'b0}}, status_q};
        default:    reg_rdata = '0;
      endcase
    end
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_q == $past(wdata_lo)) else $error("control write lost"); // R9

  AST_BAD_ADDR_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !addr_ok) |-> reg_rdata == '0) else $error("read on bad address"); // R2

endmodule

// File: rtl/rl_timer_core.sv
module rl_timer_core
  import rl_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl_q,
  input  ctrl_t             ctrl_nxt,
  input  logic              ext_lvl,
  input  logic              ext_rise,
  input  logic              wr_count,
  input  logic              wr_reload,
  input  logic              wr_status,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] count_q,
  output logic [DATA_W-1:0] reload_q,
  output logic              status_q,
  output logic              irq_o
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic              tick;
  logic              at_one;
  logic              at_zero;
  logic              sw_cnt;
  logic              hw_set;
  logic              cnt_ld;
  logic [DATA_W-1:0] count_d;
  logic              status_d;
  logic              irq_d;

  always_comb begin
    tick    = ctrl_q.en & (~ctrl_q.gate | ext_lvl) & (~ctrl_q.xclk | ext_rise);
    at_one  = (count_q == ONE);
    at_zero = (count_q == '0);
    sw_cnt  = wr_count | wr_reload;
    hw_set  = tick & at_one & ~sw_cnt;
    cnt_ld  = sw_cnt | tick;

    if (sw_cnt) begin
      count_d = wdata;
    end else if (at_one || at_zero) begin
      count_d = reload_q;
    end else begin
      count_d = count_q - ONE;
    end

    status_d = hw_set | (status_q & ~(wr_status & wdata[0]));
    irq_d    = status_d & ctrl_nxt.ie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (cnt_ld) begin
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (wr_reload) begin
      reload_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_o    <= irq_d;
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !wr_count && !wr_reload) |=> $stable(count_q)) else $error("count moved while off"); // R3

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_q > ONE && !wr_count && !wr_reload) |=> count_q == $past(count_q) - ONE) else $error("bad step"); // R3

  AST_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_one && !wr_count && !wr_reload) |=> (status_q && count_q == $past(reload_q))) else $error("expiry wrong"); // R6

  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && reload_q == '0 && !wr_count && !wr_reload) |=> count_q == '0) else $error("zero count moved"); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> status_q) else $error("event flag lost"); // R7

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (status_q & ctrl_q.ie)) else $error("irq mismatch"); // R8

endmodule

// File: rtl/rl_timer.sv
module rl_timer
  import rl_timer_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_in,
  output logic              irq_o
);

  ctrl_t             ctrl_q;
  ctrl_t             ctrl_nxt;
  logic              wr_count;
  logic              wr_reload;
  logic              wr_status;
  logic              ext_lvl;
  logic              ext_rise;
  logic [DATA_W-1:0] count_q;
  logic [DATA_W-1:0] reload_q;
  logic              status_q;

  rl_timer_extin #(
    .SYNC_STAGES(SYNC_STAGES)
  ) extin_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_in   (ext_in),
    .ext_lvl  (ext_lvl),
    .ext_rise (ext_rise)
  );

  rl_timer_regif #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) regif_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .wdata_lo  (reg_wdata[CTRL_W-1:0]),
    .count_q   (count_q),
    .reload_q  (reload_q),
    .status_q  (status_q),
    .ctrl_q    (ctrl_q),
    .ctrl_nxt  (ctrl_nxt),
    .wr_count  (wr_count),
    .wr_reload (wr_reload),
    .wr_status (wr_status),
    .reg_rdata (reg_rdata)
  );

  rl_timer_core #(
    .DATA_W(DATA_W)
  ) core_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_q    (ctrl_q),
    .ctrl_nxt  (ctrl_nxt),
    .ext_lvl   (ext_lvl),
    .ext_rise  (ext_rise),
    .wr_count  (wr_count),
    .wr_reload (wr_reload),
    .wr_status (wr_status),
    .wdata     (reg_wdata),
    .count_q   (count_q),
    .reload_q  (reload_q),
    .status_q  (status_q),
    .irq_o     (irq_o)
  );

endmodule

// File: tb/rl_timer_tb_top.sv
`timescale 1ns/1ps
module rl_timer_tb_top;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_CNT  = 8'h04;
  localparam logic [7:0] A_RLD  = 8'h08;
  localparam logic [7:0] A_STAT = 8'h0C;

  logic        clk;
  logic        rst_n;
  logic        reg_valid;
  logic        reg_write;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        ext_in;
  logic        irq_o;

  int checks;
  int errors;
  bit done;

  rl_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ext_in    (ext_in),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // Every task starts and ends just after a falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_valid = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk_reg("R1 ctrl", A_CTRL, 0);
    chk_reg("R1 count", A_CNT, 0);
    chk_reg("R1 reload", A_RLD, 0);
    chk_reg("R1 status", A_STAT, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_regmap;
    wr(A_RLD, 32'h1234_5678);
    chk_reg("R2 reload rd", A_RLD, 32'h1234_5678);
    chk_reg("R2 reload loads count", A_CNT, 32'h1234_5678);
    wr(A_CNT, 32'h0000_ABCD);
    chk_reg("R2 count rd", A_CNT, 32'h0000_ABCD);
    chk_reg("R2 count write keeps reload", A_RLD, 32'h1234_5678);
    wr(8'h05, 32'h0000_0011);
    chk_reg("R2 unaligned write ignored", A_CNT, 32'h0000_ABCD);
    wr(8'h14, 32'h0000_0022);
    chk_reg("R2 out of range write ignored", A_CNT, 32'h0000_ABCD);
    chk_reg("R2 bad address reads zero", 8'h16, 0);
  endtask

  task automatic t_enable;
    wr(A_RLD, 20);
    idle(10);
    chk_reg("R3 hold while off", A_CNT, 20);
    wr(A_CTRL, 1);
    idle(4);
    wr(A_CTRL, 0);           // steps at five edges
    chk_reg("R3 free run count", A_CNT, 15);
    idle(10);
    chk_reg("R3 hold after stop", A_CNT, 15);
  endtask

  task automatic t_expire;
    wr(A_RLD, 3);
    wr(A_CTRL, 1);
    idle(2);
    wr(A_CTRL, 0);           // 3 -> 2 -> 1 -> 3
    chk_reg("R6 reloaded after 1", A_CNT, 3);
    chk_reg("R6 flag set", A_STAT, 1);
    chk("R8 irq masked", {31'b0, irq_o}, 0);
    wr(A_CTRL, 8);
    chk("R8 irq follows enable", {31'b0, irq_o}, 1);
    wr(A_STAT, 0);
    chk_reg("R7 write 0 keeps flag", A_STAT, 1);
    chk("R7 irq kept", {31'b0, irq_o}, 1);
    wr(A_STAT, 1);
    chk_reg("R7 write 1 clears flag", A_STAT, 0);
    chk("R8 irq drops with flag", {31'b0, irq_o}, 0);
  endtask

  task automatic t_set_wins;
    wr(A_CNT, 2);
    wr(A_CTRL, 9);
    idle(1);
    wr(A_STAT, 1);           // lands on the expiry edge
    chk_reg("R7 set wins over clear", A_STAT, 1);
    chk("R8 irq on collision", {31'b0, irq_o}, 1);
    wr(A_CTRL, 0);
    chk("R8 irq off with ie clear", {31'b0, irq_o}, 0);
    wr(A_STAT, 1);
  endtask

  task automatic t_zero;
    wr(A_RLD, 7);
    wr(A_CNT, 0);
    chk_reg("R2 count write keeps reload 7", A_RLD, 7);
    wr(A_CTRL, 1);
    wr(A_CTRL, 0);           // one step from 0
    chk_reg("R6 zero loads reload", A_CNT, 7);
    chk_reg("R6 no flag from zero", A_STAT, 0);
    wr(A_RLD, 0);
    wr(A_CNT, 1);
    wr(A_CTRL, 1);
    idle(10);
    wr(A_CTRL, 0);
    chk_reg("R6 reload 0 count", A_CNT, 0);
    chk_reg("R6 reload 0 one flag", A_STAT, 1);
    wr(A_STAT, 1);
    wr(A_CTRL, 1);
    idle(10);
    wr(A_CTRL, 0);
    chk_reg("R6 stays at 0", A_CNT, 0);
    chk_reg("R6 no further flags", A_STAT, 0);
  endtask

  task automatic t_gate;
    ext_in = 1'b0;
    wr(A_RLD, 50);
    wr(A_CTRL, 3);
    idle(10);
    chk_reg("R4 gated low holds", A_CNT, 50);
    ext_in = 1'b1;
    idle(6);
    ext_in = 1'b0;
    idle(6);
    chk_reg("R4 gated high steps", A_CNT, 44);
    wr(A_CTRL, 0);
  endtask

  task automatic t_xclk;
    ext_in = 1'b0;
    wr(A_RLD, 100);
    wr(A_CTRL, 5);
    idle(8);
    chk_reg("R5 no edge no step", A_CNT, 100);
    for (int i = 0; i < 4; i++) begin
      ext_in = 1'b1;
      idle(3);
      ext_in = 1'b0;
      idle(3);
    end
    idle(4);
    chk_reg("R5 one step per rise", A_CNT, 96);
    ext_in = 1'b1;
    idle(12);
    chk_reg("R5 steady high one step", A_CNT, 95);
    wr(A_CTRL, 0);
    ext_in = 1'b0;
    idle(3);
  endtask

  task automatic t_ctrl_upper;
    wr(A_RLD, 10);
    wr(A_CTRL, 32'hFFFF_FFF0);
    chk_reg("R9 upper bits read zero", A_CTRL, 0);
    idle(5);
    chk_reg("R9 upper bits no effect", A_CNT, 10);
    wr(A_CTRL, 32'hFFFF_FFF8);
    chk_reg("R9 only low bits kept", A_CTRL, 8);
    wr(A_CTRL, 0);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    reg_valid = 1'b0; reg_write = 1'b0; reg_addr = '0; reg_wdata = '0;
    ext_in = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_enable();
    t_expire();
    t_set_wins();
    t_zero();
    t_gate();
    t_xclk();
    t_ctrl_upper();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule